// File: doc/BRIEF.md
# Drawing-Engine Command Queue with Status Word

This block sits between the host register path and a drawing engine. Each register write the host issues arrives as an address/data pair on a push port and is stored in an in-order queue. The engine drains the queue through a take/response port: it asserts a take strobe while an entry is available, and the entry appears one cycle later, read from a memory that maps onto block RAM.

A 32-bit status word reports the queue and the engine at once. The low twelve bits count the free queue slots, and the count stays exact down to zero. Two busy bits cover the raster side and the frame-buffer side. Two sticky error flags record a push that arrived while the queue was full and a read of an address that has no readable register. Software clears an error flag by writing a one to its bit. Software can also read the status word through a simple read port. The status word is driven on its own output too, so that neighbouring logic can watch it.

Software keeps a margin of spare slots before it pushes. For that reason the free count must never run ahead of the true fill level, and a push that the queue cannot hold is dropped and flagged, not stored.

Top module: `gfx_cmd_queue`

## Requirements
- R1: After reset the status word is `DEPTH` in bits 11:0 and zero elsewhere (with both engine busy inputs low), and `out_avail` is low.
- R2: Status bits 11:0 equal `DEPTH` minus the number of stored entries, updated on the same edge that accepts a push or a take, and exact down to 0.
- R3: A push while the queue holds `DEPTH` entries is dropped (nothing is stored, the count is unchanged) and sets the sticky overflow flag in status bit 31.
- R4: Entries leave in the order they were pushed: a take while `out_avail` is high produces `out_dvalid` high on the next cycle, with that entry's address and data on `out_addr`/`out_data`.
- R5: Status bit 25 (raster busy) is 1 when the queue is non-empty or `raster_busy_in` was high at the last edge. Status bit 24 (frame-buffer busy) is 1 when the queue is non-empty or `fb_busy_in` was high. Both read 0 only when the queue is empty and the matching input is low.
- R6: A read request whose address differs from `STATUS_ADDR` returns `rd_data` = 0 with `rd_ack` on the next cycle and sets the sticky read-error flag in status bit 30.
- R7: A status write with bit 31 or bit 30 set clears that flag; other bits of the write have no effect. When a new error event occurs on the same cycle as the clear, the flag stays set.
- R8: A read request to `STATUS_ADDR` returns, one cycle later with `rd_ack`, the status word as it stood on the request cycle. Status bits 23:12 and 29:26 always read 0.
- R9: A take while the queue is empty is ignored: `out_dvalid` stays low and the free count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push a command entry this cycle |
| push_addr | input | AW | Register address of the pushed entry |
| push_data | input | DW | Register data of the pushed entry |
| out_avail | output | 1 | Queue holds at least one entry |
| out_take | input | 1 | Engine takes the head entry |
| out_dvalid | output | 1 | Taken entry is on out_addr/out_data |
| out_addr | output | AW | Address of the taken entry |
| out_data | output | DW | Data of the taken entry |
| raster_busy_in | input | 1 | Raster side of the engine is working |
| fb_busy_in | input | 1 | Frame-buffer side of the engine is working |
| rd_req | input | 1 | Register read request |
| rd_addr | input | AW | Register read address |
| rd_ack | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| stat_wr | input | 1 | Write to the status word (write-one-to-clear flags) |
| stat_wdata | input | 32 | Status write data |
| status | output | 32 | Current status word |

## Verification
The bound checker watches several rules on every cycle. It checks that the free count never exceeds the depth and that an accepted push lowers it by exactly one. It checks that a full-queue push and a bad-address read raise their flags on the next cycle, and that a non-empty queue always shows both busy bits. It checks that an empty-queue take never yields data and that a clear with no competing event drops the flag. Only the directed scenarios can show the rest. Those scenarios show that entries come out in push order across a full wrap of the memory, and that a dropped push leaves the stored contents untouched. They also show that the read port returns the exact status word, and that a clear landing on the same cycle as a fresh error leaves the flag set.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int STAT_W      = 32;
  localparam int FREE_W      = 12;
  localparam int FB_BUSY_BIT = 24;
  localparam int RP_BUSY_BIT = 25;
  localparam int RDERR_BIT   = 30;
  localparam int OVF_BIT     = 31;

  function automatic logic [STAT_W-1:0] pack_status(
    input logic [FREE_W-1:0] free_slots,
    input logic              fb_busy,
    input logic              rp_busy,
    input logic              rd_err,
    input logic              ovf
  );
    logic [STAT_W-1:0] w;
    w = '0;
    w[FREE_W-1:0]  = free_slots;
    w[FB_BUSY_BIT] = fb_busy;
    w[RP_BUSY_BIT] = rp_busy;
    w[RDERR_BIT]   = rd_err;
    w[OVF_BIT]     = ovf;
    return w;
  endfunction
endpackage

// File: rtl/cmdq_ram.sv
module cmdq_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 48,
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTRW-1:0]  wa,
  input  logic [WIDTH-1:0] wd,
  input  logic             re,
  input  logic [PTRW-1:0]  ra,
  output logic [WIDTH-1:0] rq
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  always_ff @(posedge clk) begin
    if (re) rq <= mem[ra];
  end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl #(
  parameter int DEPTH = 64,
  localparam int PTRW = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_valid,
  input  logic            out_take,
  output logic            out_avail,
  output logic            out_dvalid,
  output logic            ram_we,
  output logic [PTRW-1:0] ram_wa,
  output logic            ram_re,
  output logic [PTRW-1:0] ram_ra,
  output logic [CW-1:0]   cnt_nxt,
  output logic            ovf_evt
);
  localparam logic [CW-1:0]   DEPTH_C = CW'(DEPTH);
  localparam logic [PTRW-1:0] LAST_P  = PTRW'(DEPTH - 1);
  localparam bit IS_POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [CW-1:0]   cnt_q;
  logic [PTRW-1:0] wptr_q, rptr_q, wptr_inc, rptr_inc;
  logic            dvalid_q;
  logic            full, empty, push_ok, take_ok;

  assign full    = (cnt_q == DEPTH_C);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_valid && !full;
  assign take_ok = out_take && !empty;
  assign ovf_evt = push_valid && full;

  generate
    if (IS_POW2) begin : g_wrap_free
      assign wptr_inc = wptr_q + 1'b1;
      assign rptr_inc = rptr_q + 1'b1;
    end else begin : g_wrap_cmp
      assign wptr_inc = (wptr_q == LAST_P) ? '0 : wptr_q + 1'b1;
      assign rptr_inc = (rptr_q == LAST_P) ? '0 : rptr_q + 1'b1;
    end
  endgenerate

  always_comb begin
    unique case ({push_ok, take_ok})
      2'b10:   cnt_nxt = cnt_q + 1'b1;
      2'b01:   cnt_nxt = cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      wptr_q   <= '0;
      rptr_q   <= '0;
      dvalid_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      dvalid_q <= take_ok;
      if (push_ok) wptr_q <= wptr_inc;
      if (take_ok) rptr_q <= rptr_inc;
    end
  end

  assign out_avail  = !empty;
  assign out_dvalid = dvalid_q;
  assign ram_we     = push_ok;
  assign ram_wa     = wptr_q;
  assign ram_re     = take_ok;
  assign ram_ra     = rptr_q;
endmodule

// File: rtl/cmdq_status.sv
module cmdq_status
  import cmdq_pkg::*;
#(
  parameter int          DEPTH       = 64,
  parameter int          AW          = 16,
  parameter logic [AW-1:0] STATUS_ADDR = 16'h0040,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cnt_nxt,
  input  logic              ovf_evt,
  input  logic              raster_busy_in,
  input  logic              fb_busy_in,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [STAT_W-1:0] status,
  output logic              rd_ack,
  output logic [STAT_W-1:0] rd_data
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [STAT_W-1:0] stat_q;
  logic              rderr_evt, hit;
  logic              ovf_n, rderr_n, nonempty_n;
  logic [FREE_W-1:0] free_n;

  assign hit        = (rd_addr == STATUS_ADDR);
  assign rderr_evt  = rd_req && !hit;
  assign nonempty_n = (cnt_nxt != '0);
  assign free_n     = FREE_W'(DEPTH_C - cnt_nxt);

  assign ovf_n   = ovf_evt   | (stat_q[OVF_BIT]   & ~(stat_wr & stat_wdata[OVF_BIT]));
  assign rderr_n = rderr_evt | (stat_q[RDERR_BIT] & ~(stat_wr & stat_wdata[RDERR_BIT]));

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= pack_status(FREE_W'(DEPTH), 1'b0, 1'b0, 1'b0, 1'b0);
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      stat_q  <= pack_status(free_n,
                             nonempty_n | fb_busy_in,
                             nonempty_n | raster_busy_in,
                             rderr_n, ovf_n);
      rd_ack  <= rd_req;
      rd_data <= (rd_req && hit) ? stat_q : '0;
    end
  end

  assign status = stat_q;
endmodule

// File: rtl/gfx_cmd_queue.sv
module gfx_cmd_queue #(
  parameter int            DEPTH       = 64,
  parameter int            AW          = 16,
  parameter int            DW          = 32,
  parameter logic [AW-1:0] STATUS_ADDR = 16'h0040
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_valid,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          out_avail,
  input  logic          out_take,
  output logic          out_dvalid,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data,
  input  logic          raster_busy_in,
  input  logic          fb_busy_in,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ack,
  output logic [31:0]   rd_data,
  input  logic          stat_wr,
  input  logic [31:0]   stat_wdata,
  output logic [31:0]   status
);
  localparam int PTRW = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int EW   = AW + DW;

  logic            ram_we, ram_re, ovf_evt;
  logic [PTRW-1:0] ram_wa, ram_ra;
  logic [CW-1:0]   cnt_nxt;
  logic [EW-1:0]   ram_q;

  cmdq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst(rst),
    .push_valid(push_valid), .out_take(out_take),
    .out_avail(out_avail), .out_dvalid(out_dvalid),
    .ram_we(ram_we), .ram_wa(ram_wa),
    .ram_re(ram_re), .ram_ra(ram_ra),
    .cnt_nxt(cnt_nxt), .ovf_evt(ovf_evt)
  );

  cmdq_ram #(.DEPTH(DEPTH), .WIDTH(EW)) i_ram (
    .clk(clk),
    .we(ram_we), .wa(ram_wa), .wd({push_addr, push_data}),
    .re(ram_re), .ra(ram_ra), .rq(ram_q)
  );

  cmdq_status #(.DEPTH(DEPTH), .AW(AW), .STATUS_ADDR(STATUS_ADDR)) i_stat (
    .clk(clk), .rst(rst),
    .cnt_nxt(cnt_nxt), .ovf_evt(ovf_evt),
    .raster_busy_in(raster_busy_in), .fb_busy_in(fb_busy_in),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .status(status), .rd_ack(rd_ack), .rd_data(rd_data)
  );

  assign out_addr = ram_q[EW-1:DW];
  assign out_data = ram_q[DW-1:0];
endmodule

// File: rtl/cmdq_checker.sv
module cmdq_checker #(
  parameter int            DEPTH       = 64,
  parameter int            AW          = 16,
  parameter int            DW          = 32,
  parameter logic [AW-1:0] STATUS_ADDR = 16'h0040
) (
  input logic          clk,
  input logic          rst,
  input logic          push_valid,
  input logic [AW-1:0] push_addr,
  input logic [DW-1:0] push_data,
  input logic          out_avail,
  input logic          out_take,
  input logic          out_dvalid,
  input logic [AW-1:0] out_addr,
  input logic [DW-1:0] out_data,
  input logic          raster_busy_in,
  input logic          fb_busy_in,
  input logic          rd_req,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ack,
  input logic [31:0]   rd_data,
  input logic          stat_wr,
  input logic [31:0]   stat_wdata,
  input logic [31:0]   status
);
  // R2: free count never above the depth
  a_r2_free_bound: assert property (@(posedge clk) disable iff (rst)
    status[11:0] <= 12'(DEPTH));

  // R2: accepted push alone lowers the free count by one
  a_r2_push_decrements: assert property (@(posedge clk) disable iff (rst)
    (push_valid && status[11:0] != 12'd0 && !(out_take && out_avail))
    |=> status[11:0] == $past(status[11:0]) - 12'd1);

  // R3: push into a full queue raises the overflow flag
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push_valid && status[11:0] == 12'd0) |=> status[31]);

  // R5: a non-empty queue shows both busy bits
  a_r5_busy_nonempty: assert property (@(posedge clk) disable iff (rst)
    out_avail |-> (status[25] && status[24]));

  // R6: bad-address read answers zero and flags
  a_r6_bad_read: assert property (@(posedge clk) disable iff (rst)
    (rd_req && rd_addr != STATUS_ADDR) |=> (rd_ack && rd_data == 32'd0 && status[30]));

  // R7: clear without a competing event drops the overflow flag
  a_r7_clear_ovf: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && stat_wdata[31] && !(push_valid && status[11:0] == 12'd0))
    |=> !status[31]);

  // R9: take on an empty queue yields no data
  a_r9_empty_take: assert property (@(posedge clk) disable iff (rst)
    (out_take && !out_avail) |=> !out_dvalid);

  // R8: reserved bits stay zero
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (status[23:12] == 12'd0 && status[29:26] == 4'd0));
endmodule

bind gfx_cmd_queue cmdq_checker #(
  .DEPTH(DEPTH), .AW(AW), .DW(DW), .STATUS_ADDR(STATUS_ADDR)
) i_cmdq_checker (.*);

// File: tb/test_gfx_cmd_queue.sv
module test_gfx_cmd_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] SADDR = 16'h0040;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          push_valid = 1'b0;
  logic [AW-1:0] push_addr = '0;
  logic [DW-1:0] push_data = '0;
  logic          out_avail, out_dvalid, rd_ack;
  logic          out_take = 1'b0;
  logic [AW-1:0] out_addr;
  logic [DW-1:0] out_data;
  logic          raster_busy_in = 1'b0, fb_busy_in = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data, status;
  logic          stat_wr = 1'b0;
  logic [31:0]   stat_wdata = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  gfx_cmd_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .STATUS_ADDR(SADDR)) i_gfx_cmd_queue (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_exp(int free, bit busy_fb, bit busy_rp, bit rderr, bit ovf);
    return {ovf, rderr, 4'd0, busy_rp, busy_fb, 12'd0, 12'(free)};
  endfunction

  task automatic t_reset();
    chk("R1 status", status, stat_exp(DEPTH, 0, 0, 0, 0));
    chk("R1 out_avail", 32'(out_avail), 32'd0);
  endtask

  task automatic t_fill_order();
    for (int i = 0; i < 3; i++) begin
      push_valid = 1'b1; push_addr = AW'(16'h0100 + i); push_data = 32'hA000_0000 + i;
      step();
    end
    push_valid = 1'b0;
    chk("R2 free after 3 pushes", status, stat_exp(DEPTH - 3, 1, 1, 0, 0));
    chk("R5 busy with entries", 32'(status[25:24]), 32'd3);
    out_take = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R4 dvalid", 32'(out_dvalid), 32'd1);
      chk("R4 order addr", 32'(out_addr), 32'h0100 + i);
      chk("R4 order data", out_data, 32'hA000_0000 + i);
    end
    out_take = 1'b0;
    chk("R5 idle after drain", status, stat_exp(DEPTH, 0, 0, 0, 0));
    chk("R4 avail low after drain", 32'(out_avail), 32'd0);
  endtask

  task automatic t_full_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      push_valid = 1'b1; push_addr = AW'(i); push_data = 32'h5500_0000 + i;
      step();
    end
    chk("R2 free at zero", status, stat_exp(0, 1, 1, 0, 0));
    push_addr = 16'hFFFF; push_data = 32'hDEAD_BEEF;
    step();
    push_valid = 1'b0;
    chk("R3 overflow flag, count kept", status, stat_exp(0, 1, 1, 0, 1));
    // R7: clear of bit 31 on the same cycle as a new overflow; flag stays
    push_valid = 1'b1; stat_wr = 1'b1; stat_wdata = 32'h8000_0000;
    step();
    push_valid = 1'b0; stat_wr = 1'b0;
    chk("R7 set wins over clear", 32'(status[31]), 32'd1);
    out_take = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      step();
      if (i == 0 || i == DEPTH - 1) begin
        chk("R3 stored entries intact addr", 32'(out_addr), 32'(i));
        chk("R3 stored entries intact data", out_data, 32'h5500_0000 + i);
      end
    end
    out_take = 1'b0;
    chk("R3 dropped push not stored", 32'(out_avail), 32'd0);
    chk("R2 free back to depth", status, stat_exp(DEPTH, 0, 0, 0, 1));
  endtask

  task automatic t_reads();
    logic [31:0] snap;
    rd_req = 1'b1; rd_addr = 16'h0041;
    step();
    rd_req = 1'b0;
    chk("R6 ack", 32'(rd_ack), 32'd1);
    chk("R6 data zero", rd_data, 32'd0);
    chk("R6 flag set", status, stat_exp(DEPTH, 0, 0, 1, 1));
    snap = status;
    rd_req = 1'b1; rd_addr = SADDR;
    step();
    rd_req = 1'b0;
    chk("R8 status read", rd_data, snap);
    chk("R8 no new error", 32'(status[30]), 32'd1);
    // R7: bad read with clear of bit 30 on the same cycle
    rd_req = 1'b1; rd_addr = 16'h0000; stat_wr = 1'b1; stat_wdata = 32'h4000_0000;
    step();
    rd_req = 1'b0; stat_wr = 1'b0;
    chk("R7 rderr set wins", 32'(status[30]), 32'd1);
  endtask

  task automatic t_w1c();
    stat_wr = 1'b1; stat_wdata = 32'h4000_0000;
    step();
    chk("R7 clear bit 30 only", status, stat_exp(DEPTH, 0, 0, 0, 1));
    stat_wdata = 32'h8000_0FFF;
    step();
    stat_wr = 1'b0;
    chk("R7 clear bit 31, low bits ignored", status, stat_exp(DEPTH, 0, 0, 0, 0));
  endtask

  task automatic t_engine_busy();
    raster_busy_in = 1'b1;
    step();
    chk("R5 raster busy only", status, stat_exp(DEPTH, 0, 1, 0, 0));
    raster_busy_in = 1'b0; fb_busy_in = 1'b1;
    step();
    chk("R5 fb busy only", status, stat_exp(DEPTH, 1, 0, 0, 0));
    fb_busy_in = 1'b0;
    step();
    chk("R5 idle", status, stat_exp(DEPTH, 0, 0, 0, 0));
  endtask

  task automatic t_empty_take();
    out_take = 1'b1;
    step();
    out_take = 1'b0;
    chk("R9 no data on empty take", 32'(out_dvalid), 32'd0);
    chk("R9 free unchanged", status, stat_exp(DEPTH, 0, 0, 0, 0));
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_fill_order();
    t_full_overflow();
    t_reads();
    t_w1c();
    t_engine_busy();
    t_empty_take();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule